// File: doc/BRIEF.md
# Transfer-Information DMA Length Controller

This block runs the DMA side of a transfer-information command in a small bus-adapter core. When it is launched, it combines the two programmed transfer-count bytes into a 16-bit length. It then clips that length, either to a 32-byte cap while command bytes are being collected or to the magnitude of the device's signed residual transfer size. The sign of the residual sets the direction. A negative residual means data flows out of memory toward the device.

The block moves the clipped number of bytes over a request/acknowledge handshake toward memory. Each accepted byte moves the residual one step toward zero. When the bytes run out, it decides whether to finish at once or to wait for the device to report that it is done. On finishing, it sets the count-zero status flag, records the bus-service cause, clears the count, pulses a strobe that clears the sequence-step and flags registers kept outside the block, and raises its interrupt.

The controller has five states:
- IDLE waits for `start`.
- XFER requests bytes until none are left.
- EVAL chooses how to finish.
- WAIT holds until `dev_done`.
- DONE writes the completion values.

Its transitions are:
- launch: IDLE to XFER, on `start`.
- drained: XFER to EVAL, when the bytes left reach zero.
- finish_now: EVAL to DONE.
- defer: EVAL to WAIT.
- device_done: WAIT to DONE.
- retire: DONE to IDLE.

Top module: `ti_dma_len_ctrl`

## Requirements
- R1: The programmed length is `{cnt_mid, cnt_lo}`, with `cnt_mid` as the upper byte. It appears on `count_q` from the cycle after launch until completion.
- R2: With `cmd_phase` high at launch, the burst length is min(programmed length, 32), `mem_dir` is 0, the residual is left untouched, and completion follows without waiting for the device.
- R3: With a negative residual at launch, the burst length is min(programmed length, |residual|) and `mem_dir` is 1.
- R4: With a zero or positive residual at launch, the burst length is min(programmed length, residual) and `mem_dir` is 0.
- R5: A launch clears `stat_tc`, `irq` and `intr_cause`, loads `bytes_left` and `burst_len` with the burst length, and raises `busy` in the next cycle.
- R6: `mem_req` is high exactly while a transfer has bytes left. Each cycle with `mem_req` and `mem_ack` both high decrements `bytes_left` by one and, outside the command phase, moves `resid_out` one step toward zero.
- R7: Completion sets `stat_tc`, sets `intr_cause` to 8'h10 (bus service), clears `count_q`, pulses `clr_seq_flags` for one cycle, raises `irq` and drops `busy`.
- R8: If the residual is still positive when the bytes left reach zero, because the device owes more data, completion follows at once.
- R9: If `buf_partial` is high when the bytes left reach zero, because the device buffer was only partly used, completion follows at once.
- R10: In any other case the block holds `busy` with `irq` low until `dev_done` is seen.
- R11: A `start` pulse while `busy` is high is ignored. The burst length, byte count and direction of the running transfer do not change.
- R12: After reset the block is idle, all counters and registers are zero, and `mem_req` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse for a transfer-information command |
| cmd_phase | input | 1 | Command bytes are being collected |
| cnt_lo | input | 8 | Low byte of the programmed transfer count |
| cnt_mid | input | 8 | High byte of the programmed transfer count |
| resid_in | input | RES_W | Signed residual device transfer size |
| buf_partial | input | 1 | Device buffer was only partly filled or drained |
| dev_done | input | 1 | Device reports that its part of the transfer is finished |
| mem_ack | input | 1 | Memory accepts the requested byte |
| mem_req | output | 1 | Byte request toward memory |
| mem_dir | output | 1 | 1 = memory to device, 0 = device to memory |
| busy | output | 1 | Transfer in progress |
| burst_len | output | CNT_W | Burst length computed at launch |
| bytes_left | output | CNT_W | Bytes still to move in this burst |
| resid_out | output | RES_W | Residual device size, tracked per byte |
| count_q | output | CNT_W | Transfer count register |
| stat_tc | output | 1 | Count-zero status flag |
| intr_cause | output | 8 | Interrupt cause register |
| irq | output | 1 | Interrupt request |
| clr_seq_flags | output | 1 | One-cycle strobe to clear the sequence-step and flags registers |

## Verification
The assertions check on every cycle that:
- requests appear only while busy and only with bytes left;
- every accepted byte takes exactly one from the count and one step off the residual;
- a start pulse while busy leaves the burst length and direction untouched;
- the wait state never raises the interrupt without `dev_done`;
- the interrupt rises only together with the count-zero flag, the bus-service cause and a cleared count.

The bench scenarios cover:
- that the length is the right minimum for each mix of count, cap and residual sign;
- that exactly that many bytes move;
- which way each ending goes (immediate or deferred);
- the final residual after a burst.

// File: rtl/tidl_pkg.sv
package tidl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_XFER,
        S_EVAL,
        S_WAIT,
        S_DONE
    } state_t;

    localparam logic [7:0] CAUSE_BUS_SVC = 8'h10;
endpackage

// File: rtl/tidl_len_calc.sv
// Burst length: programmed count clipped by the command cap or residual size.
module tidl_len_calc #(
    parameter int CNT_W   = 16,
    parameter int RES_W   = 24,
    parameter int CMD_CAP = 32
) (
    input  logic [CNT_W-1:0]        prog,
    input  logic signed [RES_W-1:0] resid,
    input  logic                    cmd,
    output logic [CNT_W-1:0]        len
);
    localparam int CW = (RES_W > CNT_W) ? RES_W : CNT_W;

    logic [RES_W-1:0] mag;
    logic [CW-1:0]    lim_w;
    logic [CW-1:0]    prog_w;

    always_comb begin
        mag    = resid[RES_W-1] ? RES_W'(-resid) : RES_W'(resid);
        lim_w  = cmd ? CW'(CMD_CAP) : CW'(mag);
        prog_w = CW'(prog);
        len    = (lim_w < prog_w) ? lim_w[CNT_W-1:0] : prog;
    end
endmodule

// File: rtl/tidl_track.sv
// Bytes-left counter and residual tracker.
module tidl_track #(
    parameter int CNT_W = 16,
    parameter int RES_W = 24
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load,
    input  logic                    take,
    input  logic [CNT_W-1:0]        len,
    input  logic signed [RES_W-1:0] resid_in,
    input  logic                    cmd,
    output logic [CNT_W-1:0]        left_q,
    output logic signed [RES_W-1:0] resid_q,
    output logic                    cmd_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q  <= '0;
            resid_q <= '0;
            cmd_q   <= 1'b0;
        end else if (load) begin
            left_q  <= len;
            resid_q <= resid_in;
            cmd_q   <= cmd;
        end else if (take) begin
            left_q <= left_q - CNT_W'(1);
            if (!cmd_q) begin
                if (resid_q[RES_W-1])
                    resid_q <= resid_q + RES_W'(1);
                else if (resid_q != '0)
                    resid_q <= resid_q - RES_W'(1);
            end
        end
    end
endmodule

// File: rtl/ti_dma_len_ctrl.sv
module ti_dma_len_ctrl #(
    parameter int CNT_W   = 16,
    parameter int RES_W   = 24,
    parameter int CMD_CAP = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    cmd_phase,
    input  logic [7:0]              cnt_lo,
    input  logic [7:0]              cnt_mid,
    input  logic signed [RES_W-1:0] resid_in,
    input  logic                    buf_partial,
    input  logic                    dev_done,
    input  logic                    mem_ack,
    output logic                    mem_req,
    output logic                    mem_dir,
    output logic                    busy,
    output logic [CNT_W-1:0]        burst_len,
    output logic [CNT_W-1:0]        bytes_left,
    output logic signed [RES_W-1:0] resid_out,
    output logic [CNT_W-1:0]        count_q,
    output logic                    stat_tc,
    output logic [7:0]              intr_cause,
    output logic                    irq,
    output logic                    clr_seq_flags
);
    import tidl_pkg::*;

    state_t                    state_q, state_d;
    logic [CNT_W-1:0]          prog;
    logic [CNT_W-1:0]          len;
    logic [CNT_W-1:0]          left_q;
    logic signed [RES_W-1:0]   resid_q;
    logic                      cmd_q;
    logic                      load, take;

    assign prog = CNT_W'({cnt_mid, cnt_lo});

    tidl_len_calc #(.CNT_W(CNT_W), .RES_W(RES_W), .CMD_CAP(CMD_CAP)) u_len (
        .prog  (prog),
        .resid (resid_in),
        .cmd   (cmd_phase),
        .len   (len)
    );

    tidl_track #(.CNT_W(CNT_W), .RES_W(RES_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .take     (take),
        .len      (len),
        .resid_in (resid_in),
        .cmd      (cmd_phase),
        .left_q   (left_q),
        .resid_q  (resid_q),
        .cmd_q    (cmd_q)
    );

    assign load = (state_q == S_IDLE) && start;
    assign take = mem_req && mem_ack;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_XFER;
            S_XFER: if (left_q == '0) state_d = S_EVAL;
            S_EVAL: begin
                if (cmd_q || (resid_q > 0) || buf_partial) state_d = S_DONE;
                else                                      state_d = S_WAIT;
            end
            S_WAIT: if (dev_done) state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_len  <= '0;
            count_q    <= '0;
            stat_tc    <= 1'b0;
            intr_cause <= '0;
            irq        <= 1'b0;
            mem_dir    <= 1'b0;
        end else if (load) begin
            burst_len  <= len;
            count_q    <= prog;
            stat_tc    <= 1'b0;
            intr_cause <= '0;
            irq        <= 1'b0;
            mem_dir    <= !cmd_phase && resid_in[RES_W-1];
        end else if (state_q == S_DONE) begin
            count_q    <= '0;
            stat_tc    <= 1'b1;
            intr_cause <= CAUSE_BUS_SVC;
            irq        <= 1'b1;
        end
    end

    assign mem_req       = (state_q == S_XFER) && (left_q != '0);
    assign busy          = (state_q != S_IDLE);
    assign clr_seq_flags = (state_q == S_DONE);
    assign bytes_left    = left_q;
    assign resid_out     = resid_q;
endmodule

// File: rtl/tidl_chk.sv
module tidl_chk #(
    parameter int CNT_W = 16,
    parameter int RES_W = 24
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    dev_done,
    input logic                    mem_req,
    input logic                    mem_ack,
    input logic                    mem_dir,
    input logic                    busy,
    input logic [CNT_W-1:0]        burst_len,
    input logic [CNT_W-1:0]        bytes_left,
    input logic signed [RES_W-1:0] resid_out,
    input logic [CNT_W-1:0]        count_q,
    input logic                    stat_tc,
    input logic [7:0]              intr_cause,
    input logic                    irq,
    input logic                    cmd_q,
    input tidl_pkg::state_t        state_q
);
    import tidl_pkg::*;

    a_r6_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy && bytes_left != '0));

    a_r6_left_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (bytes_left == $past(bytes_left) - CNT_W'(1)));

    a_r6_resid_up: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !cmd_q && resid_out < 0) |=> (resid_out == $past(resid_out) + 1));

    a_r6_resid_down: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && !cmd_q && resid_out > 0) |=> (resid_out == $past(resid_out) - 1));

    a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(burst_len) && $stable(mem_dir)));

    a_r10_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAIT && !dev_done) |=> (!irq && busy));

    a_r7_irq_with_status: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (stat_tc && intr_cause == CAUSE_BUS_SVC && count_q == '0 && !busy));
endmodule

bind ti_dma_len_ctrl tidl_chk #(.CNT_W(CNT_W), .RES_W(RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dev_done   (dev_done),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_dir    (mem_dir),
    .busy       (busy),
    .burst_len  (burst_len),
    .bytes_left (bytes_left),
    .resid_out  (resid_out),
    .count_q    (count_q),
    .stat_tc    (stat_tc),
    .intr_cause (intr_cause),
    .irq        (irq),
    .cmd_q      (cmd_q),
    .state_q    (state_q)
);

// File: tb/sim_ti_dma_len_ctrl.sv
module sim_ti_dma_len_ctrl;
    localparam int CNT_W = 16;
    localparam int RES_W = 24;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    start = 1'b0;
    logic                    cmd_phase = 1'b0;
    logic [7:0]              cnt_lo = '0;
    logic [7:0]              cnt_mid = '0;
    logic signed [RES_W-1:0] resid_in = '0;
    logic                    buf_partial = 1'b0;
    logic                    dev_done = 1'b0;
    logic                    mem_ack = 1'b0;
    logic                    mem_req, mem_dir, busy, stat_tc, irq, clr_seq_flags;
    logic [CNT_W-1:0]        burst_len, bytes_left, count_q;
    logic signed [RES_W-1:0] resid_out;
    logic [7:0]              intr_cause;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ti_dma_len_ctrl #(.CNT_W(CNT_W), .RES_W(RES_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_phase(cmd_phase),
        .cnt_lo(cnt_lo), .cnt_mid(cnt_mid), .resid_in(resid_in),
        .buf_partial(buf_partial), .dev_done(dev_done), .mem_ack(mem_ack),
        .mem_req(mem_req), .mem_dir(mem_dir), .busy(busy), .burst_len(burst_len),
        .bytes_left(bytes_left), .resid_out(resid_out), .count_q(count_q),
        .stat_tc(stat_tc), .intr_cause(intr_cause), .irq(irq),
        .clr_seq_flags(clr_seq_flags)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int prog, input int r, input bit cmd);
        int lim;
        lim = cmd ? 32 : ((r < 0) ? -r : r);
        return (lim < prog) ? lim : prog;
    endfunction

    function automatic int exp_resid(input int r, input int len, input bit cmd);
        if (cmd) return r;
        return (r < 0) ? r + len : r - len;
    endfunction

    task automatic run_case(input logic [7:0] lo, input logic [7:0] mid, input int r,
                            input bit cmd, input bit partial, input bit poke);
        int prog, len, rfin, acks, clr_seen;
        bit wait_dev, poked;
        string lreq;
        prog     = int'(mid) * 256 + int'(lo);
        len      = exp_len(prog, r, cmd);
        rfin     = exp_resid(r, len, cmd);
        wait_dev = !cmd && (rfin <= 0) && !partial;
        lreq     = cmd ? "R2" : ((r < 0) ? "R3" : "R4");

        @(negedge clk);
        cnt_lo = lo; cnt_mid = mid; resid_in = RES_W'(r);
        cmd_phase = cmd; buf_partial = partial; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !stat_tc && !irq && intr_cause == 0, "R5 launch clears status", busy, 1);
        chk(int'(count_q) == prog, "R1 programmed length", count_q, prog);
        chk(int'(burst_len) == len, lreq, burst_len, len);
        chk(int'(bytes_left) == len, "R5 bytes_left load", bytes_left, len);
        chk(mem_dir == (!cmd && r < 0), lreq, mem_dir, (!cmd && r < 0));

        acks = 0; poked = 0;
        for (int k = 0; k < 4000 && acks < len; k++) begin
            if (k > 0) @(negedge clk);
            if (poke && acks == 1 && !poked) begin
                start = 1'b1; cnt_lo = 8'hFF; cnt_mid = 8'h7F; cmd_phase = !cmd; poked = 1;
            end else begin
                start = 1'b0;
            end
            mem_ack = ($urandom % 3) != 0;
            if (mem_req && mem_ack) acks++;
        end
        @(negedge clk);
        mem_ack = 1'b0; start = 1'b0;
        chk(acks == len, "R6 bytes moved", acks, len);
        chk(!mem_req && bytes_left == 0, "R6 request drops at zero", mem_req, 0);
        chk(int'(resid_out) == rfin, "R6 residual tracking", resid_out, rfin);
        if (poke) begin
            chk(int'(burst_len) == len, "R11 start while busy ignored", burst_len, len);
            chk(int'(count_q) == prog, "R11 count unchanged", count_q, prog);
        end

        clr_seen = 0;
        if (wait_dev) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (clr_seq_flags) clr_seen++;
            end
            chk(busy && !irq, "R10 waits for device", busy, 1);
            dev_done = 1'b1;
            @(negedge clk);
            dev_done = 1'b0;
            if (clr_seq_flags) clr_seen++;
        end
        for (int k = 0; k < 10 && busy; k++) begin
            @(negedge clk);
            if (clr_seq_flags) clr_seen++;
        end
        if (!wait_dev)
            chk(!busy, cmd ? "R2 completes at once" : (partial ? "R9 partial completes" : "R8 owed data completes"), busy, 0);
        chk(!busy && stat_tc && irq, "R7 completion flags", {busy, stat_tc, irq}, 3);
        chk(intr_cause == 8'h10, "R7 cause", intr_cause, 16);
        chk(count_q == 0, "R7 count cleared", count_q, 0);
        chk(clr_seen == 1, "R7 clear strobe", clr_seen, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !irq && !stat_tc, "R12 reset idle", busy, 0);
        chk(bytes_left == 0 && count_q == 0 && burst_len == 0 && resid_out == 0 && intr_cause == 0,
            "R12 reset zero", bytes_left, 0);
        rst_n = 1'b1;

        run_case(8'd100, 8'd0, 5, 1'b1, 1'b0, 1'b0);    // R2 cap
        run_case(8'd10, 8'd0, -40, 1'b1, 1'b0, 1'b0);   // R2 below cap
        run_case(8'd20, 8'd0, -50, 1'b0, 1'b0, 1'b0);   // R3 host owes more: wait
        run_case(8'd60, 8'd0, -12, 1'b0, 1'b0, 1'b0);   // R3 clipped by residual
        run_case(8'd15, 8'd0, 40, 1'b0, 1'b0, 1'b0);    // R8 device owes more
        run_case(8'd50, 8'd0, 9, 1'b0, 1'b0, 1'b0);     // R4 drained: wait
        run_case(8'd50, 8'd0, 9, 1'b0, 1'b1, 1'b0);     // R9 partial buffer
        run_case(8'd0, 8'd1, 300, 1'b0, 1'b0, 1'b0);    // R1 high byte only
        run_case(8'd0, 8'd0, 7, 1'b0, 1'b0, 1'b0);      // zero count
        run_case(8'd30, 8'd0, 0, 1'b0, 1'b0, 1'b0);     // zero residual
        run_case(8'd25, 8'd0, -25, 1'b0, 1'b0, 1'b1);   // R11 start during transfer

        for (int i = 0; i < 40; i++) begin
            int r;
            r = int'($urandom % 161) - 80;
            run_case(8'($urandom % 70), ((($urandom % 8) == 0) ? 8'd1 : 8'd0), r,
                     (($urandom % 4) == 0), (($urandom % 3) == 0), (($urandom % 5) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule